// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns a column command into the beat-by-beat column stream of an SDRAM burst. It is meant for the data path of a two-bank SDRAM model or controller. A READ or WRITE command carries a start column. The block then presents one column per cycle in the wrap order that the mode word selects, for as many beats as the programmed burst length. Write beats pass through with their byte enables. Array read data is captured in each read beat and delivered after the programmed CAS latency. Row, bank and refresh handling live in a separate tracker. The storage array sits outside the block and answers `col_addr` combinationally on `arr_rd_data`.

Both edges of the block are free-running streams. A command is accepted in the cycle `cmd_valid` is high; there is no ready, because the memory side can never stall. `rd_valid` qualifies `rd_data` for one cycle and cannot be back-pressured. A consumer that cannot take a beat must size its own buffering for a full burst. A new READ or WRITE restarts the sequence at once. A terminate or precharge operation silences it in the cycle it arrives.

The mode word is seven bits wide:
- bits 2..0 give the burst length code;
- bit 3 gives the wrap order;
- bits 6..4 give the read latency code.

Top module: `sdram_burst_seq`

## Requirements
- R1: `mode_load` copies `mode_word` into the mode register only when both code fields are legal. Burst length codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats. Bit 3 = 0 selects sequential order and bit 3 = 1 selects interleaved order. Latency codes 001, 010 and 011 give 1, 2 and 3 cycles. A load that carries any other code is dropped whole. A load is also ignored in any cycle that has a command, a beat, or read data still in flight.
- R2: `cmd_op` 0 is READ and 1 is WRITE. Either one presents `cmd_col` on `col_addr` with `col_valid` high in the same cycle. `col_is_read` is high for READ.
- R3: In sequential order, beat k places (start + k) mod BL in the low log2(BL) column bits. All higher bits keep the start value.
- R4: In interleaved order, beat k places start XOR k in the low log2(BL) column bits. All higher bits keep the start value.
- R5: An undisturbed burst gives exactly BL consecutive beats. `burst_done` is high on the last beat only. With BL = 1 that is the command cycle itself.
- R6: On a write beat, `wr_en` is high and `wr_data_out` equals `wr_data_in`. `wr_byte_en` is the inverse of `byte_mask` in that same cycle.
- R7: The array word seen during a read beat appears on `rd_data` with `rd_valid` high exactly CL cycles later. In every other cycle `rd_valid`, `rd_byte_en` and `rd_data` are zero.
- R8: When `rd_valid` is high, byte lane i is disabled if `byte_mask[i]` was high two cycles earlier. A disabled lane has `rd_byte_en[i]` low and zero data.
- R9: A READ or WRITE that arrives during a burst ends that burst. The new command's burst starts in the same cycle from its own column.
- R10: `cmd_op` 2 (terminate) and 3 (precharge) end the ongoing burst, and no beat is presented in their cycle. Read beats already issued still deliver their data.
- R11: After reset there are no beats and no read data. The mode is BL = 1, sequential order, CL = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Request to load the mode register |
| mode_word | input | 7 | Length code [2:0], order [3], latency code [6:4] |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 READ, 1 WRITE, 2 terminate, 3 precharge |
| cmd_col | input | 9 | Start column for READ and WRITE |
| byte_mask | input | 8 | Per-lane mask, used by writes and (delayed) by reads |
| wr_data_in | input | 64 | Write data for the current beat |
| arr_rd_data | input | 64 | Array word for the current `col_addr` |
| col_valid | output | 1 | A beat is presented this cycle |
| col_addr | output | 9 | Column of the current beat |
| col_is_read | output | 1 | Current beat belongs to a read |
| burst_done | output | 1 | Current beat is the last of its burst |
| wr_en | output | 1 | Write beat strobe |
| wr_byte_en | output | 8 | Lane enables for the write beat |
| wr_data_out | output | 64 | Write data to the array |
| rd_valid | output | 1 | Read data valid |
| rd_byte_en | output | 8 | Lane enables for the read data |
| rd_data | output | 64 | Read data, disabled lanes zero |

## Verification
Bursts are run at every length, in both wrap orders, from start columns whose low bits are not aligned. Column 0x1FE tells modulo wrap apart from carry into the upper bits, and the interleaved runs separate XOR from addition. Reads run at all three latencies while a rotating single-lane mask is active. This exposes any off-by-one in the latency tap or the two-cycle mask delay. Back-to-back commands, terminate and precharge after a partial burst, and reserved or badly timed mode loads show that restarts, stops and the register guard change exactly the beats the requirements name.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_TERM  = 2'd2,
    OP_PRECH = 2'd3
  } sbs_op_e;

  typedef struct packed {
    logic [1:0] bl_log;     // log2 of burst length
    logic       interleave; // 1: xor order, 0: modulo-add order
    logic [1:0] cas_lat;    // read latency in cycles, 1..3
  } sbs_mode_t;

  localparam sbs_mode_t MODE_RESET = '{bl_log: 2'd0, interleave: 1'b0, cas_lat: 2'd3};

  function automatic logic len_code_ok(input logic [2:0] code);
    return code[2] == 1'b0;
  endfunction

  function automatic logic lat_code_ok(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
  endfunction

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  logic [6:0] word,
  input  logic      hold_off,
  output sbs_mode_t mode
);

  logic accept;

  always_comb begin
    accept = load && !hold_off && len_code_ok(word[2:0]) && lat_code_ok(word[6:4]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_RESET;
    end else if (accept) begin
      mode.bl_log     <= word[1:0];
      mode.interleave <= word[3];
      mode.cas_lat    <= word[5:4];
    end
  end

endmodule

// File: rtl/sbs_beat_ctl.sv
module sbs_beat_ctl
  import sbs_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [1:0]       bl_log,
  output logic             beat_live,
  output logic             beat_rd,
  output logic [COL_W-1:0] beat_base,
  output logic [IDX_W-1:0] beat_idx,
  output logic             beat_last
);

  logic             busy_q;
  logic             rd_q;
  logic [COL_W-1:0] base_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  logic             start;
  logic             stop;

  always_comb begin
    start = cmd_valid && !cmd_op[1];
    stop  = cmd_valid && cmd_op[1];
    for (int b = 0; b < IDX_W; b++) begin
      last_idx[b] = (b < int'(bl_log));
    end
    if (start) begin
      beat_live = 1'b1;
      beat_rd   = (cmd_op == OP_READ);
      beat_base = cmd_col;
      beat_idx  = '0;
    end else begin
      beat_live = busy_q && !stop;
      beat_rd   = rd_q;
      beat_base = base_q;
      beat_idx  = idx_q;
    end
    beat_last = beat_live && (beat_idx == last_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= beat_live && !beat_last;
      if (beat_live) begin
        rd_q   <= beat_rd;
        base_q <= beat_base;
        idx_q  <= beat_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbs_col_order.sv
module sbs_col_order #(
  parameter int COL_W = 9,
  parameter int IDX_W = 3
) (
  input  logic [COL_W-1:0] base,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       bl_log,
  input  logic             interleave,
  output logic [COL_W-1:0] col
);

  logic [IDX_W-1:0] seq_low;
  logic [IDX_W-1:0] xor_low;
  logic [IDX_W-1:0] pick;

  always_comb begin
    seq_low = base[IDX_W-1:0] + idx;
    xor_low = base[IDX_W-1:0] ^ idx;
    pick    = interleave ? xor_low : seq_low;
  end

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < IDX_W) begin : g_low
      assign col[b] = (b < int'(bl_log)) ? pick[b] : base[b];
    end else begin : g_high
      assign col[b] = base[b];
    end
  end

endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
  parameter int LANES  = 8,
  parameter int MAX_CL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [LANES*8-1:0] in_data,
  input  logic [LANES-1:0]   lane_mask,
  input  logic [1:0]         cas_lat,
  output logic               out_valid,
  output logic [LANES-1:0]   out_en,
  output logic [LANES*8-1:0] out_data,
  output logic               pending
);

  localparam int DATA_W = LANES * 8;
  localparam int TAP_W  = $clog2(MAX_CL);

  logic [MAX_CL-1:0] st_v;
  logic [DATA_W-1:0] st_d [MAX_CL];
  logic [LANES-1:0]  mask_d1;
  logic [LANES-1:0]  mask_d2;
  logic [TAP_W-1:0]  tap;
  logic [DATA_W-1:0] tap_d;

  for (genvar s = 0; s < MAX_CL; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_v[0] <= 1'b0;
          st_d[0] <= '0;
        end else begin
          st_v[0] <= in_valid;
          st_d[0] <= in_valid ? in_data : '0;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_v[s] <= 1'b0;
          st_d[s] <= '0;
        end else begin
          st_v[s] <= st_v[s-1];
          st_d[s] <= st_d[s-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_d1 <= '0;
      mask_d2 <= '0;
    end else begin
      mask_d1 <= lane_mask;
      mask_d2 <= mask_d1;
    end
  end

  always_comb begin
    tap       = TAP_W'(cas_lat - 2'd1);
    out_valid = st_v[tap];
    tap_d     = st_d[tap];
    pending   = |st_v;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign out_en[l]           = out_valid && !mask_d2[l];
    assign out_data[l*8 +: 8]  = out_en[l] ? tap_d[l*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int COL_W      = 9,
  parameter int MAX_BL_LOG = 3,
  parameter int MAX_CL     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_load,
  input  logic [6:0]         mode_word,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [COL_W-1:0]   cmd_col,
  input  logic [LANES-1:0]   byte_mask,
  input  logic [LANES*8-1:0] wr_data_in,
  input  logic [LANES*8-1:0] arr_rd_data,
  output logic               col_valid,
  output logic [COL_W-1:0]   col_addr,
  output logic               col_is_read,
  output logic               burst_done,
  output logic               wr_en,
  output logic [LANES-1:0]   wr_byte_en,
  output logic [LANES*8-1:0] wr_data_out,
  output logic               rd_valid,
  output logic [LANES-1:0]   rd_byte_en,
  output logic [LANES*8-1:0] rd_data
);

  localparam int DATA_W = LANES * 8;

  sbs_mode_t             mode;
  logic                  beat_live;
  logic                  beat_rd;
  logic [COL_W-1:0]      beat_base;
  logic [MAX_BL_LOG-1:0] beat_idx;
  logic                  beat_last;
  logic                  rd_pending;
  logic                  mode_hold;

  assign mode_hold = cmd_valid || beat_live || rd_pending;

  sbs_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (mode_load),
    .word     (mode_word),
    .hold_off (mode_hold),
    .mode     (mode)
  );

  sbs_beat_ctl #(.COL_W(COL_W), .IDX_W(MAX_BL_LOG)) u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_col   (cmd_col),
    .bl_log    (mode.bl_log),
    .beat_live (beat_live),
    .beat_rd   (beat_rd),
    .beat_base (beat_base),
    .beat_idx  (beat_idx),
    .beat_last (beat_last)
  );

  sbs_col_order #(.COL_W(COL_W), .IDX_W(MAX_BL_LOG)) u_order (
    .base       (beat_base),
    .idx        (beat_idx),
    .bl_log     (mode.bl_log),
    .interleave (mode.interleave),
    .col        (col_addr)
  );

  sbs_rd_pipe #(.LANES(LANES), .MAX_CL(MAX_CL)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (beat_live && beat_rd),
    .in_data   (arr_rd_data),
    .lane_mask (byte_mask),
    .cas_lat   (mode.cas_lat),
    .out_valid (rd_valid),
    .out_en    (rd_byte_en),
    .out_data  (rd_data),
    .pending   (rd_pending)
  );

  always_comb begin
    col_valid   = beat_live;
    col_is_read = beat_live && beat_rd;
    burst_done  = beat_last;
    wr_en       = beat_live && !beat_rd;
    wr_byte_en  = wr_en ? ~byte_mask : '0;
    wr_data_out = wr_en ? wr_data_in : {DATA_W{1'b0}};
  end

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int LANES      = 8,
  parameter int COL_W      = 9,
  parameter int MAX_BL_LOG = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [1:0]         cmd_op,
  input logic [COL_W-1:0]   cmd_col,
  input logic [LANES-1:0]   byte_mask,
  input logic               col_valid,
  input logic [COL_W-1:0]   col_addr,
  input logic               col_is_read,
  input logic               burst_done,
  input logic               wr_en,
  input logic [LANES-1:0]   wr_byte_en,
  input logic               rd_valid,
  input logic [LANES-1:0]   rd_byte_en,
  input logic [LANES*8-1:0] rd_data
);

  AST_START_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_op[1]) |-> (col_valid && col_addr == cmd_col && col_is_read == (cmd_op == 2'd0))); // R2

  AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1]) |-> (!col_valid && !wr_en)); // R10

  AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !burst_done) |=> (col_valid || cmd_valid)); // R5

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && burst_done) |=> (!col_valid || (cmd_valid && !cmd_op[1]))); // R5

  AST_UPPER_COL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !burst_done) |=>
      (cmd_valid || col_addr[COL_W-1:MAX_BL_LOG] == $past(col_addr[COL_W-1:MAX_BL_LOG]))); // R3

  AST_WRITE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (col_valid && !col_is_read && wr_byte_en == ~byte_mask)); // R6

  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_byte_en == '0 && rd_data == '0)); // R7

endmodule

bind sdram_burst_seq sbs_checker #(
  .LANES(LANES), .COL_W(COL_W), .MAX_BL_LOG(MAX_BL_LOG)
) i_chk (.*);

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_load = 1'b0;
  logic [6:0]  mode_word = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [8:0]  cmd_col = '0;
  logic [7:0]  byte_mask = '0;
  logic [63:0] wr_data_in = '0;
  logic [63:0] arr_rd_data;
  logic        col_valid;
  logic [8:0]  col_addr;
  logic        col_is_read;
  logic        burst_done;
  logic        wr_en;
  logic [7:0]  wr_byte_en;
  logic [63:0] wr_data_out;
  logic        rd_valid;
  logic [7:0]  rd_byte_en;
  logic [63:0] rd_data;

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_burst_seq i_sdram_burst_seq (.*);

  function automatic logic [63:0] arr_word(input logic [8:0] c);
    logic [63:0] w;
    for (int l = 0; l < 8; l++) w[l*8 +: 8] = c[7:0] ^ 8'((l * 29) & 255) ^ {7'b0, c[8]};
    return w;
  endfunction

  always_comb arr_rd_data = arr_word(col_addr);

  typedef struct {int at; logic [8:0] col; bit rd; bit last; string req;} beat_t;
  typedef struct {int at; logic [63:0] data; string req;} rdx_t;

  beat_t bq[$];
  rdx_t  rq[$];
  logic [7:0] mask_hist [int];
  int tests = 0, fails = 0;
  bit mon_on = 0, mask_on = 0, ml_arm = 0, finished = 0;
  logic [6:0] ml_word = '0;
  int bl = 1, bt = 0, cl = 3;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [6:0] mw(input int blc, input int bto, input int clc);
    return {3'(clc), 1'(bto), 3'(blc)};
  endfunction

  function automatic logic [8:0] mcol(input logic [8:0] s, input int k);
    int m  = bl - 1;
    int si = int'(s);
    int lo = bt ? (((si & m) ^ k) & m) : (((si & m) + k) & m);
    return 9'((si & ~m) | lo);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
    cmd_valid  = 1'b0;
    cmd_op     = '0;
    cmd_col    = '0;
    mode_load  = 1'b0;
    byte_mask  = mask_on ? 8'(1 << (cyc % 8)) : 8'h00;
    mask_hist[cyc] = byte_mask;
    wr_data_in = {8{8'(cyc)}} ^ 64'h0123_4567_89AB_CDEF;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic set_mode(input logic [6:0] w, input bit accept);
    step();
    mode_load = 1'b1;
    mode_word = w;
    if (accept) begin
      bl = 1 << w[1:0];
      bt = int'(w[3]);
      cl = int'(w[5:4]);
    end
  endtask

  // Driver: issues one command, then gap-1 quiet cycles, and pushes expectations.
  task automatic cmd(input int op, input logic [8:0] col, input int gap, input string req);
    int n;
    step();
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_col   = col;
    n = (op < 2) ? ((bl < gap) ? bl : gap) : 0;
    for (int k = 0; k < n; k++) begin
      beat_t b;
      b.at = cyc + k; b.col = mcol(col, k); b.rd = (op == 0); b.last = (k == bl - 1); b.req = req;
      bq.push_back(b);
      if (op == 0) begin
        rdx_t r;
        r.at = cyc + k + cl; r.data = arr_word(mcol(col, k)); r.req = req;
        rq.push_back(r);
      end
    end
    for (int g = 1; g < gap; g++) begin
      step();
      if (g == 1 && ml_arm) begin
        mode_load = 1'b1;
        mode_word = ml_word;
        ml_arm    = 1'b0;
      end
    end
  endtask

  // Monitor: pops expectations and compares them against the ports.
  beat_t cb;
  rdx_t  cr;
  logic [7:0]  exp_en;
  logic [63:0] exp_rd;
  always @(negedge clk) begin
    if (mon_on) begin
      while (bq.size() > 0 && bq[0].at < cyc) begin
        chk(1'b0, bq[0].req, "R5 beat missing", 64'(0), 64'(bq[0].col));
        void'(bq.pop_front());
      end
      if (bq.size() > 0 && bq[0].at == cyc) begin
        cb = bq.pop_front();
        chk(col_valid, cb.req, "R2 beat valid", 64'(col_valid), 64'(1));
        chk(col_addr == cb.col, cb.req, "column order", 64'(col_addr), 64'(cb.col));
        chk(col_is_read == cb.rd, cb.req, "R2 read flag", 64'(col_is_read), 64'(cb.rd));
        chk(burst_done == cb.last, cb.req, "R5 done flag", 64'(burst_done), 64'(cb.last));
        if (!cb.rd) begin
          chk(wr_en && wr_byte_en == ~byte_mask, cb.req, "R6 write enables",
              64'(wr_byte_en), 64'(~byte_mask));
          chk(wr_data_out == wr_data_in, cb.req, "R6 write data", wr_data_out, wr_data_in);
        end else begin
          chk(!wr_en, cb.req, "R6 no write on read beat", 64'(wr_en), 64'(0));
        end
      end else begin
        chk(!col_valid && !wr_en, "R10", "unexpected beat", 64'(col_valid), 64'(0));
      end

      while (rq.size() > 0 && rq[0].at < cyc) begin
        chk(1'b0, rq[0].req, "R7 read data missing", 64'(0), rq[0].data);
        void'(rq.pop_front());
      end
      if (rq.size() > 0 && rq[0].at == cyc) begin
        cr = rq.pop_front();
        exp_en = mask_hist.exists(cyc - 2) ? ~mask_hist[cyc - 2] : 8'hFF;
        for (int l = 0; l < 8; l++) exp_rd[l*8 +: 8] = exp_en[l] ? cr.data[l*8 +: 8] : 8'h00;
        chk(rd_valid, cr.req, "R7 read valid at latency", 64'(rd_valid), 64'(1));
        chk(rd_byte_en == exp_en, cr.req, "R8 read lane enables", 64'(rd_byte_en), 64'(exp_en));
        chk(rd_data == exp_rd, cr.req, "R7 R8 read data", rd_data, exp_rd);
      end else begin
        chk(!rd_valid && rd_byte_en == 0 && rd_data == 0, "R7", "unexpected read data",
            64'(rd_valid), 64'(0));
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!col_valid && !burst_done && !wr_en, "R11", "no beat after reset", 64'(col_valid), 64'(0));
    chk(!rd_valid && rd_byte_en == 0, "R11", "no read data after reset", 64'(rd_valid), 64'(0));
    mon_on = 1'b1;

    // R11: reset mode is BL1, sequential, CL3
    cmd(0, 9'h012, 5, "R11");
    cmd(0, 9'h0E7, 5, "R11");
    idle(5);

    // R3: sequential BL4 CL2 with a rotating read mask
    set_mode(mw(2, 0, 2), 1'b1);
    mask_on = 1'b1;
    cmd(0, 9'h0A6, 6, "R3");
    cmd(1, 9'h0A6, 6, "R6");
    idle(5);

    // R4: interleaved BL8 CL3
    set_mode(mw(3, 1, 3), 1'b1);
    cmd(0, 9'h135, 10, "R4");
    cmd(1, 9'h1FE, 10, "R4");
    idle(5);

    // R3: sequential BL8 CL1, wrap without carry into upper bits
    set_mode(mw(3, 0, 1), 1'b1);
    cmd(1, 9'h1FE, 9, "R3");
    cmd(0, 9'h0F3, 9, "R7");

    // R9: new command cuts a burst short
    cmd(0, 9'h040, 3, "R9");
    cmd(1, 9'h155, 2, "R9");
    cmd(0, 9'h0C7, 9, "R9");
    idle(5);

    // R10: terminate and precharge
    cmd(0, 9'h021, 2, "R10");
    cmd(2, 9'h000, 3, "R10");
    cmd(1, 9'h033, 3, "R10");
    cmd(3, 9'h000, 4, "R10");
    idle(5);

    // R5: BL1, done on the command cycle, back to back
    set_mode(mw(0, 0, 1), 1'b1);
    cmd(0, 9'h100, 1, "R5");
    cmd(0, 9'h0FF, 1, "R5");
    cmd(1, 9'h101, 1, "R5");
    cmd(0, 9'h102, 2, "R5");
    idle(5);

    // R1: reserved codes are rejected whole
    set_mode(mw(4, 1, 2), 1'b0);
    set_mode(mw(1, 1, 0), 1'b0);
    set_mode(mw(2, 0, 7), 1'b0);
    cmd(0, 9'h077, 3, "R1");
    idle(5);

    // R1: legal load BL2 interleaved CL2
    set_mode(mw(1, 1, 2), 1'b1);
    cmd(0, 9'h0AB, 3, "R1");
    cmd(1, 9'h0AB, 3, "R1");
    idle(5);

    // R1: load during a burst is ignored
    set_mode(mw(3, 0, 3), 1'b1);
    ml_word = mw(0, 1, 1);
    ml_arm  = 1'b1;
    cmd(0, 9'h012, 9, "R1");
    cmd(0, 9'h0FD, 9, "R1");
    idle(8);

    chk(bq.size() == 0 && rq.size() == 0, "R5", "all expected beats seen",
        64'(bq.size() + rq.size()), 64'(0));
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule